// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Controller

This block sits on the host side of a four-channel, 12-bit serial DAC. A client hands it a channel number and a code through a ready/valid request; the controller builds a 16-bit frame and shifts it out on a serial data line. The frame is two address bits, two padding bits, then the code, and it is sent with a generated serial clock and an active-low chip select. When the last bit has been taken, the controller pulses the active-low load strobe so that the addressed channel register copies the code.

The serial clock half-period comes from a divider input, so one build serves slow and fast parts. The converter's channel latches are transparent while the load strobe is low, and its shift register is clocked by the OR of chip select and serial clock. The controller therefore keeps the strobe high while shifting, and it raises chip select only while the serial clock is high. A separate request input drives the converter's active-low reset line for a fixed number of cycles. A configuration input chooses whether that reset clears the channels to zero-scale or to mid-scale, and the controller passes that choice to the converter.

Top module: `dacw_ctrl`

## Requirements
- R1: Each write sends 16 bits, most significant first: channel address bit 1, address bit 0, two zero padding bits, then code bits 11 down to 0. After the write, only the addressed channel of the converter holds the new code.
- R2: The serial data output changes only in the cycle where the serial clock falls, or while chip select is high. It is stable while the serial clock is high.
- R3: The serial clock idles high. Chip select falls while the serial clock is high and rises only while it is high. The OR of the two shows exactly 16 rising edges per frame.
- R4: The load strobe stays high whenever chip select is low. After chip select rises, the strobe goes low for exactly LOAD_W system clock cycles.
- R5: busy is high from the cycle after a request is accepted until the load strobe is high again. req_ready is high only when the controller is idle and no reset is requested.
- R6: Each serial clock low phase lasts clk_div+1 system clock cycles.
- R7: A reset request taken while idle drives the converter reset line low for exactly RST_W cycles. All four channels then read 0x000 when rst_mid is 0, or 0x800 when rst_mid is 1. rst_sel follows rst_mid one cycle later.
- R8: A request presented while busy is not accepted. It has no effect on any channel.
- R9: When a reset request and a write request are present together while idle, the reset is taken and the write is not accepted.
- R10: After rst_n, chip select, serial clock, load strobe and the converter reset line are all high, busy is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Write request can be accepted this cycle |
| req_chan | input | 2 | Target channel address |
| req_code | input | 12 | Code for the target channel |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system clock cycles |
| reset_req | input | 1 | Request a converter reset pulse |
| rst_mid | input | 1 | Reset level select: 0 for zero-scale, 1 for mid-scale |
| busy | output | 1 | Transfer or reset pulse in progress |
| dac_sclk | output | 1 | Serial clock to the converter |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sdi | output | 1 | Serial data to the converter |
| dac_load_n | output | 1 | Active-low load strobe for the channel latches |
| dac_rst_n | output | 1 | Active-low converter reset |
| dac_rst_sel | output | 1 | Reset level select driven to the converter |

## Verification
A wrong shift register or bit counter shows at the ports as a wrong count of OR-clock edges, or as the wrong channel or code in the converter model. This is visible once the load strobe rises at the end of the same frame. A wrong state sequence shows in the cycle it happens: chip select rises while the serial clock is low, the load strobe falls while chip select is low, or busy drops while the strobe is still low. A wrong timer limit shows as a serial clock phase, strobe width or reset width that is off by one or more cycles. These are measured on every frame.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
    localparam int ADDR_W  = 2;
    localparam int PAD_W   = 2;
    localparam int CODE_W  = 12;
    localparam int FRAME_W = ADDR_W + PAD_W + CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_LOAD,
        ST_RESET
    } dacw_state_e;

    typedef struct packed {
        dacw_state_e state;
        logic        sclk;
        logic        cs_n;
        logic        sdi;
        logic        load_n;
        logic        dac_rst_n;
        logic        rst_sel;
    } dacw_regs_t;
endpackage

// File: rtl/dacw_timer.sv
module dacw_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == limit);

    always_comb begin
        if (restart)      cnt_d = '0;
        else if (expired) cnt_d = cnt_q;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] frame,
    input  logic         shift,
    output logic         msb,
    output logic         empty
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     sr;
        logic [CNT_W-1:0] cnt;
    } sh_t;

    sh_t s_d, s_q;

    assign msb   = s_q.sr[W-1];
    assign empty = (s_q.cnt == CNT_W'(W));

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.sr  = frame;
            s_d.cnt = '0;
        end else if (shift) begin
            s_d.sr  = {s_q.sr[W-2:0], 1'b0};
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
    import dacw_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int LOAD_W = 4,
    parameter int RST_W  = 6,
    parameter int TMR_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_chan,
    input  logic [CODE_W-1:0]    req_code,
    input  logic [DIV_W-1:0]     clk_div,
    input  logic                 reset_req,
    input  logic                 rst_mid,
    output logic                 busy,
    output logic                 dac_sclk,
    output logic                 dac_cs_n,
    output logic                 dac_sdi,
    output logic                 dac_load_n,
    output logic                 dac_rst_n,
    output logic                 dac_rst_sel
);
    localparam logic [TMR_W-1:0] LOAD_LIM = TMR_W'(LOAD_W - 1);
    localparam logic [TMR_W-1:0] RST_LIM  = TMR_W'(RST_W - 1);

    dacw_regs_t r_d, r_q;

    logic             tmr_restart, tmr_expired;
    logic [TMR_W-1:0] tmr_limit;
    logic             sh_load, sh_shift, sh_msb, sh_empty;
    logic [FRAME_W-1:0] frame;

    assign frame = {req_chan, {PAD_W{1'b0}}, req_code};

    dacw_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    dacw_shifter #(.W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .frame (frame),
        .shift (sh_shift),
        .msb   (sh_msb),
        .empty (sh_empty)
    );

    assign req_ready   = (r_q.state == ST_IDLE) && !reset_req;
    assign busy        = (r_q.state != ST_IDLE);
    assign dac_sclk    = r_q.sclk;
    assign dac_cs_n    = r_q.cs_n;
    assign dac_sdi     = r_q.sdi;
    assign dac_load_n  = r_q.load_n;
    assign dac_rst_n   = r_q.dac_rst_n;
    assign dac_rst_sel = r_q.rst_sel;

    always_comb begin
        r_d         = r_q;
        r_d.rst_sel = rst_mid;
        tmr_restart = 1'b0;
        sh_load     = 1'b0;
        sh_shift    = 1'b0;

        case (r_q.state)
            ST_LOAD:  tmr_limit = LOAD_LIM;
            ST_RESET: tmr_limit = RST_LIM;
            default:  tmr_limit = TMR_W'(clk_div);
        endcase

        case (r_q.state)
            ST_IDLE: begin
                if (reset_req) begin
                    r_d.dac_rst_n = 1'b0;
                    r_d.state     = ST_RESET;
                    tmr_restart   = 1'b1;
                end else if (req_valid) begin
                    sh_load     = 1'b1;
                    r_d.cs_n    = 1'b0;
                    r_d.state   = ST_SETUP;
                    tmr_restart = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.sclk    = 1'b0;
                    r_d.sdi     = sh_msb;
                    sh_shift    = 1'b1;
                    r_d.state   = ST_LOW;
                    tmr_restart = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    r_d.sclk    = 1'b1;
                    r_d.state   = ST_HIGH;
                    tmr_restart = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    tmr_restart = 1'b1;
                    if (sh_empty) begin
                        r_d.cs_n   = 1'b1;
                        r_d.load_n = 1'b0;
                        r_d.state  = ST_LOAD;
                    end else begin
                        r_d.sclk  = 1'b0;
                        r_d.sdi   = sh_msb;
                        sh_shift  = 1'b1;
                        r_d.state = ST_LOW;
                    end
                end
            end
            ST_LOAD: begin
                if (tmr_expired) begin
                    r_d.load_n = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            ST_RESET: begin
                if (tmr_expired) begin
                    r_d.dac_rst_n = 1'b1;
                    r_d.state     = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.sclk      <= 1'b1;
            r_q.cs_n      <= 1'b1;
            r_q.sdi       <= 1'b0;
            r_q.load_n    <= 1'b1;
            r_q.dac_rst_n <= 1'b1;
            r_q.rst_sel   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dacw_ctrl_chk.sv
module dacw_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic reset_req,
    input logic busy,
    input logic dac_sclk,
    input logic dac_cs_n,
    input logic dac_sdi,
    input logic dac_load_n,
    input logic dac_rst_n
);
    assert_sdi_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sclk && $past(dac_sclk) && !dac_cs_n && !$past(dac_cs_n)) |-> $stable(dac_sdi));

    assert_cs_rise_sclk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> dac_sclk);

    assert_cs_fall_sclk_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> dac_sclk);

    assert_load_high_while_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> dac_load_n);

    assert_busy_covers_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_load_n || !dac_cs_n) |-> busy);

    assert_reset_pulse_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_rst_n |-> (dac_cs_n && dac_load_n && busy));

    assert_reset_blocks_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !req_ready);
endmodule

bind dacw_ctrl dacw_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .reset_req  (reset_req),
    .busy       (busy),
    .dac_sclk   (dac_sclk),
    .dac_cs_n   (dac_cs_n),
    .dac_sdi    (dac_sdi),
    .dac_load_n (dac_load_n),
    .dac_rst_n  (dac_rst_n)
);

// File: tb/dacw_ctrl_tb.sv
module dacw_ctrl_tb;
    localparam int DIV_W  = 8;
    localparam int LOAD_W = 4;
    localparam int RST_W  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_chan = '0;
    logic [11:0] req_code = '0;
    logic [DIV_W-1:0] clk_div = '0;
    logic        reset_req = 1'b0;
    logic        rst_mid = 1'b0;
    logic        busy, dac_sclk, dac_cs_n, dac_sdi, dac_load_n, dac_rst_n, dac_rst_sel;

    int n_checks = 0;
    int n_bad    = 0;

    always #10 clk = ~clk;

    dacw_ctrl #(.DIV_W(DIV_W), .LOAD_W(LOAD_W), .RST_W(RST_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_code(req_code), .clk_div(clk_div),
        .reset_req(reset_req), .rst_mid(rst_mid), .busy(busy),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_sdi(dac_sdi),
        .dac_load_n(dac_load_n), .dac_rst_n(dac_rst_n), .dac_rst_sel(dac_rst_sel)
    );

    // Converter model: shift register clocked by OR of select and clock,
    // transparent channel latches, asynchronous reset.
    wire or_clk = dac_cs_n | dac_sclk;
    logic [15:0] m_sr = '0;
    logic [11:0] m_reg [4];
    logic [11:0] exp_reg [4];
    int m_edges = 0;

    always @(posedge or_clk) begin
        m_sr    <= {m_sr[14:0], dac_sdi};
        m_edges <= m_edges + 1;
    end

    always @(negedge clk) begin
        if (dac_rst_n === 1'b0) begin
            for (int i = 0; i < 4; i++) m_reg[i] <= dac_rst_sel ? 12'h800 : 12'h000;
        end else if (dac_load_n === 1'b0) begin
            m_reg[m_sr[15:14]] <= m_sr[11:0];
        end
    end

    // Port monitors
    int sclk_run = 0, sclk_min = 0, sclk_max = 0;
    int load_run = 0, load_last = 0;
    int rstl_run = 0, rstl_last = 0;
    int sdi_bad = 0, busy_bad = 0;
    logic prev_sclk = 1'b1, prev_sdi = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dac_sclk) sclk_run++;
            else if (sclk_run != 0) begin
                if (sclk_min == 0 || sclk_run < sclk_min) sclk_min = sclk_run;
                if (sclk_run > sclk_max) sclk_max = sclk_run;
                sclk_run = 0;
            end
            if (!dac_load_n) load_run++;
            else if (load_run != 0) begin load_last = load_run; load_run = 0; end
            if (!dac_rst_n) rstl_run++;
            else if (rstl_run != 0) begin rstl_last = rstl_run; rstl_run = 0; end
            if (!dac_cs_n && dac_sclk && prev_sclk && dac_sdi != prev_sdi) sdi_bad++;
            if ((!dac_load_n || !dac_cs_n) && !busy) busy_bad++;
        end
        prev_sclk = dac_sclk;
        prev_sdi  = dac_sdi;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic clear_mon();
        sclk_min = 0; sclk_max = 0; load_last = 0; rstl_last = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < 4; i++)
            check(m_reg[i] === exp_reg[i], tag, int'(m_reg[i]), int'(exp_reg[i]));
    endtask

    task automatic t_reset_state();
        check(dac_cs_n && dac_sclk && dac_load_n && dac_rst_n, "R10 idle lines", 
              {dac_cs_n, dac_sclk, dac_load_n, dac_rst_n}, 4'hf);
        check(!busy && req_ready, "R10 busy/ready", {busy, req_ready}, 2'b01);
    endtask

    task automatic t_dac_reset(input bit mid);
        rst_mid = mid;
        @(negedge clk);
        clear_mon();
        reset_req = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
        check(busy && !dac_rst_n, "R7 reset started", {busy, dac_rst_n}, 2'b10);
        check(dac_rst_sel == mid, "R7 select level", dac_rst_sel, mid);
        wait_idle();
        check(rstl_last == RST_W, "R7 reset width", rstl_last, RST_W);
        for (int i = 0; i < 4; i++) exp_reg[i] = mid ? 12'h800 : 12'h000;
        compare_all("R7 channels after reset");
    endtask

    task automatic t_write(input logic [1:0] ch, input logic [11:0] code, input int div);
        int e0;
        clk_div = DIV_W'(div);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        clear_mon();
        e0 = m_edges;
        req_chan  = ch;
        req_code  = code;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !req_ready, "R5 busy after accept", {busy, req_ready}, 2'b10);
        wait_idle();
        exp_reg[ch] = code;
        check(m_edges - e0 == 16, "R3 or-clock edges", m_edges - e0, 16);
        check(m_sr == {ch, 2'b00, code}, "R1 frame bits", m_sr, {ch, 2'b00, code});
        compare_all("R1 channel contents");
        check(sclk_min == div + 1 && sclk_max == div + 1, "R6 low phase",
              sclk_max * 256 + sclk_min, (div + 1) * 257);
        check(load_last == LOAD_W, "R4 load width", load_last, LOAD_W);
        check(dac_sclk && dac_cs_n, "R3 idle high", {dac_sclk, dac_cs_n}, 2'b11);
    endtask

    task automatic t_busy_ignore();
        clk_div = 8'd1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_chan = 2'd1; req_code = 12'h5a5; req_valid = 1'b1;
        @(negedge clk);
        req_chan = 2'd3; req_code = 12'h0f0;
        for (int k = 0; k < 20; k++) begin
            check(!req_ready, "R8 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_idle();
        exp_reg[1] = 12'h5a5;
        compare_all("R8 busy request ignored");
        check(!busy, "R8 idle after one frame", busy, 0);
    endtask

    task automatic t_priority();
        int e0;
        rst_mid = 1'b0;
        @(negedge clk);
        e0 = m_edges;
        req_chan = 2'd2; req_code = 12'habc;
        reset_req = 1'b1; req_valid = 1'b1;
        #1 check(!req_ready, "R9 ready masked", req_ready, 0);
        @(negedge clk);
        reset_req = 1'b0; req_valid = 1'b0;
        check(!dac_rst_n && dac_cs_n, "R9 reset taken", {dac_rst_n, dac_cs_n}, 2'b01);
        wait_idle();
        check(m_edges == e0, "R9 no frame sent", m_edges - e0, 0);
        for (int i = 0; i < 4; i++) exp_reg[i] = 12'h000;
        compare_all("R9 channels zero");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_dac_reset(1'b1);
        t_write(2'd0, 12'h123, 0);
        t_write(2'd1, 12'hfff, 3);
        t_write(2'd2, 12'h000, 1);
        t_write(2'd3, 12'h801, 2);
        t_write(2'd2, 12'haaa, 0);
        t_dac_reset(1'b0);
        t_write(2'd3, 12'h555, 5);
        t_busy_ignore();
        t_priority();
        check(sdi_bad == 0, "R2 sdi stable while clock high", sdi_bad, 0);
        check(busy_bad == 0, "R5 busy covers transfer", busy_bad, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule